// File: doc/BRIEF.md
# Prescaled PWM Channel Generator

This block produces one pulse-width-modulated output from a shared timing tick. The tick first passes through an 8-bit prescaler that divides it by K+1. Each prescaled tick advances a 16-bit period counter, which wraps after a programmable number of steps. The output sits at its active level for the first part of each period and at the inactive level for the rest. A polarity bit chooses whether the active level is high or low.

Configuration arrives as a single write strobe with the prescale value, a 32-bit period word and the polarity bit. A write takes effect on the next clock. It also restarts the prescaler and the period counter from zero, so a running period is cut short rather than finished. The channel enable drives the output-enable pin. While the channel is off, the pad buffer is released and the pin floats, and both counters are held at zero.

Top module: `pwm_tick_channel`

## Requirements
- R1: During and directly after reset, `pwm_oe_o` is 0. All configuration fields reset to zero, which makes the polarity active-low, so `pwm_o` reads 1 (inactive).
- R2: With prescale value K (`cfg_presc_i`, 0 to 255), the period counter advances once for every K+1 cycles in which `tick_i` is 1.
- R3: The period word places the period-length field in bits 31:16 and the active-length field in bits 15:0. A period-length field of E gives a period of E+1 prescaled ticks, with the counter running from 0 to E and then back to 0.
- R4: The output is at its active level while the period counter is below the active-length field, and at the inactive level otherwise.
- R5: A polarity bit of 1 makes the active level high (`pwm_o` = 1). A polarity bit of 0 makes it low.
- R6: `pwm_oe_o` follows `chan_en_i` with one cycle of delay. While it is 0, the counters stay at zero, so the output restarts at count 0 when the channel is enabled again.
- R7: A cycle with `cfg_wr_i` = 1 loads every configuration field at the next clock edge. The same edge sets both counters to zero, even in the middle of a period.
- R8: An active-length field larger than the period-length field holds the output at its active level for the whole period.
- R9: An active-length field of 0 holds the output at its inactive level permanently.
- R10: In a cycle where `tick_i` is 0 and no write occurs, neither counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Divided tick from the shared clock stage |
| chan_en_i | input | 1 | Channel enable |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_presc_i | input | 8 | Prescale value K |
| cfg_period_i | input | 32 | [31:16] period length minus one, [15:0] active length |
| cfg_act_high_i | input | 1 | 1: active level is high |
| pwm_o | output | 1 | PWM output level |
| pwm_oe_o | output | 1 | Output enable for the pad buffer |

## Verification
- A configuration write, a tick and an enable change each take effect at the first rising edge after they are presented.
- The output enable is a register, so it follows `chan_en_i` one cycle late.
- The output level is decoded combinationally from the counter and configuration registers, so it is valid in the same cycle that the counters change.

The bench drives inputs on the falling edge and advances a behavioural integer model at the rising edge. It compares both outputs on the next falling edge, which places every comparison exactly one edge after the stimulus.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned DEF_PRESC_W = 8;
  localparam int unsigned DEF_CNT_W   = 16;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } act_level_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_chan_pkg::*;
#(
  parameter int unsigned PRESC_W = DEF_PRESC_W,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  localparam int unsigned PER_W  = 2 * CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [PER_W-1:0]   period_i,
  input  logic               act_high_i,
  output logic [PRESC_W-1:0] presc_o,
  output logic [CNT_W-1:0]   entire_o,
  output logic [CNT_W-1:0]   active_o,
  output act_level_e         level_o,
  output logic               run_o
);
  logic [PRESC_W-1:0] presc_d;
  logic [CNT_W-1:0]   entire_d, active_d;
  act_level_e         level_d;

  // Next-state: load all fields together on a write
  always_comb begin
    presc_d  = presc_o;
    entire_d = entire_o;
    active_d = active_o;
    level_d  = level_o;
    if (wr_i) begin
      presc_d  = presc_i;
      entire_d = period_i[PER_W-1:CNT_W];
      active_d = period_i[CNT_W-1:0];
      level_d  = act_high_i ? LVL_HIGH : LVL_LOW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_o  <= '0;
      entire_o <= '0;
      active_o <= '0;
      level_o  <= LVL_LOW;
      run_o    <= 1'b0;
    end else begin
      presc_o  <= presc_d;
      entire_o <= entire_d;
      active_o <= active_d;
      level_o  <= level_d;
      run_o    <= en_i;
    end
  end
endmodule

// File: rtl/pwm_wrap_cnt.sv
module pwm_wrap_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_d;
  logic         at_limit;

  assign at_limit = (cnt_o == limit_i);
  assign wrap_o   = step_i & at_limit & ~clr_i;

  always_comb begin
    cnt_d = cnt_o;
    if (clr_i)         cnt_d = '0;
    else if (step_i)   cnt_d = at_limit ? '0 : cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] active_i,
  input  act_level_e       level_i,
  input  logic             run_i,
  output logic             pwm_o,
  output logic             pwm_oe_o
);
  logic in_active;

  assign in_active = (cnt_i < active_i);
  assign pwm_o     = in_active ? level_i : ~level_i;
  assign pwm_oe_o  = run_i;
endmodule

// File: rtl/pwm_tick_channel.sv
module pwm_tick_channel
  import pwm_chan_pkg::*;
#(
  parameter int unsigned PRESC_W = DEF_PRESC_W,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  localparam int unsigned PER_W  = 2 * CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               chan_en_i,
  input  logic               cfg_wr_i,
  input  logic [PRESC_W-1:0] cfg_presc_i,
  input  logic [PER_W-1:0]   cfg_period_i,
  input  logic               cfg_act_high_i,
  output logic               pwm_o,
  output logic               pwm_oe_o
);
  logic [PRESC_W-1:0] cfg_presc;
  logic [CNT_W-1:0]   cfg_entire, cfg_active;
  act_level_e         cfg_level;
  logic               run;
  logic               cnt_clr;
  logic [PRESC_W-1:0] presc_cnt;
  logic [CNT_W-1:0]   period_cnt;
  logic               presc_wrap, period_wrap;

  pwm_cfg_regs #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr_i),
    .en_i       (chan_en_i),
    .presc_i    (cfg_presc_i),
    .period_i   (cfg_period_i),
    .act_high_i (cfg_act_high_i),
    .presc_o    (cfg_presc),
    .entire_o   (cfg_entire),
    .active_o   (cfg_active),
    .level_o    (cfg_level),
    .run_o      (run)
  );

  // Any write or an idle channel restarts both counters
  assign cnt_clr = cfg_wr_i | ~run;

  pwm_wrap_cnt #(.W(PRESC_W)) presc_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .step_i  (tick_i),
    .limit_i (cfg_presc),
    .cnt_o   (presc_cnt),
    .wrap_o  (presc_wrap)
  );

  pwm_wrap_cnt #(.W(CNT_W)) period_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .step_i  (presc_wrap),
    .limit_i (cfg_entire),
    .cnt_o   (period_cnt),
    .wrap_o  (period_wrap)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) out_i (
    .cnt_i    (period_cnt),
    .active_i (cfg_active),
    .level_i  (cfg_level),
    .run_i    (run),
    .pwm_o    (pwm_o),
    .pwm_oe_o (pwm_oe_o)
  );

  logic unused_wrap;
  assign unused_wrap = period_wrap;
endmodule

// File: rtl/pwm_tick_channel_chk.sv
module pwm_tick_channel_chk #(
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               chan_en_i,
  input logic               cfg_wr_i,
  input logic               pwm_o,
  input logic               pwm_oe_o,
  input logic [PRESC_W-1:0] presc_cnt,
  input logic [CNT_W-1:0]   period_cnt,
  input logic [PRESC_W-1:0] presc_lim,
  input logic [CNT_W-1:0]   entire_lim,
  input logic [CNT_W-1:0]   active_lim,
  input logic               level
);
  // R6
  oe_follows_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pwm_oe_o == $past(chan_en_i)));

  // R6
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_oe_o && $past(!pwm_oe_o)) |-> (period_cnt == '0 && presc_cnt == '0));

  // R7
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> (period_cnt == '0 && presc_cnt == '0));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cfg_wr_i && pwm_oe_o) |=> ($stable(presc_cnt) && $stable(period_cnt)));

  // R2
  presc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_cnt <= presc_lim);

  // R3
  period_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_cnt <= entire_lim);

  // R8
  full_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_lim > entire_lim) |-> (pwm_o == level));

  // R9
  zero_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_lim == '0) |-> (pwm_o != level));
endmodule

bind pwm_tick_channel pwm_tick_channel_chk #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .chan_en_i  (chan_en_i),
  .cfg_wr_i   (cfg_wr_i),
  .pwm_o      (pwm_o),
  .pwm_oe_o   (pwm_oe_o),
  .presc_cnt  (presc_cnt),
  .period_cnt (period_cnt),
  .presc_lim  (cfg_presc),
  .entire_lim (cfg_entire),
  .active_lim (cfg_active),
  .level      (cfg_level)
);

// File: tb/pwm_tick_channel_tb_top.sv
module pwm_tick_channel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        chan_en_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [7:0]  cfg_presc_i = '0;
  logic [31:0] cfg_period_i = '0;
  logic        cfg_act_high_i = 1'b0;
  logic        pwm_o, pwm_oe_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;
  bit done = 1'b0;

  // behavioural model state
  int m_k, m_ent, m_act, m_pc, m_cc;
  bit m_pol, m_en;

  always #10 clk_i = ~clk_i;

  pwm_tick_channel dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .chan_en_i      (chan_en_i),
    .cfg_wr_i       (cfg_wr_i),
    .cfg_presc_i    (cfg_presc_i),
    .cfg_period_i   (cfg_period_i),
    .cfg_act_high_i (cfg_act_high_i),
    .pwm_o          (pwm_o),
    .pwm_oe_o       (pwm_oe_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_k = 0; m_ent = 0; m_act = 0; m_pc = 0; m_cc = 0; m_pol = 0; m_en = 0;
    end else begin
      if (cfg_wr_i) begin
        m_k = cfg_presc_i; m_ent = cfg_period_i[31:16];
        m_act = cfg_period_i[15:0]; m_pol = cfg_act_high_i;
        m_pc = 0; m_cc = 0;
      end else if (!m_en) begin
        m_pc = 0; m_cc = 0;
      end else if (tick_i) begin
        if (m_pc == m_k) begin
          m_pc = 0;
          m_cc = (m_cc == m_ent) ? 0 : m_cc + 1;
        end else m_pc = m_pc + 1;
      end
      m_en = chan_en_i;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && !done) begin
      check({cur_req, " R6 oe"}, pwm_oe_o, m_en);
      check({cur_req, " level"}, pwm_o, (m_cc < m_act) ? m_pol : !m_pol);
    end
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic write_cfg(int k, int ent, int act, bit pol);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_presc_i = k[7:0];
    cfg_period_i = {ent[15:0], act[15:0]}; cfg_act_high_i = pol;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  // mode 0: tick every cycle, 1: every other cycle, 2: pseudo-random
  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: tick_i = 1'b1;
        1: tick_i = i[0];
        default: tick_i = lfsr[3];
      endcase
    end
  endtask

  int hi_cnt;

  initial begin
    // R1: reset state
    #35;
    check("R1 oe", pwm_oe_o, 1'b0);
    check("R1 level", pwm_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 oe after release", pwm_oe_o, 1'b0);

    cur_req = "R3 R4";
    write_cfg(0, 4, 2, 1'b1);
    chan_en_i = 1'b1;
    run(40, 0);
    // R4: two active cycles out of a five-cycle period
    hi_cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      hi_cnt += pwm_o;
    end
    checks++;
    if (hi_cnt != 2) begin
      errors++;
      $display("FAIL R4 active count actual %0d expected 2", hi_cnt);
    end

    cur_req = "R5";
    write_cfg(0, 4, 2, 1'b0);
    run(30, 0);

    cur_req = "R2 R10";
    write_cfg(2, 3, 1, 1'b1);
    run(60, 1);

    cur_req = "R7";
    run(7, 0);
    write_cfg(1, 6, 3, 1'b1);
    run(5, 0);
    write_cfg(0, 2, 1, 1'b0);
    run(20, 2);

    cur_req = "R8";
    write_cfg(0, 4, 9, 1'b1);
    run(25, 0);

    cur_req = "R9";
    write_cfg(1, 4, 0, 1'b1);
    run(25, 0);

    cur_req = "R6";
    write_cfg(0, 5, 3, 1'b1);
    run(4, 0);
    chan_en_i = 1'b0;
    run(20, 0);
    chan_en_i = 1'b1;
    run(20, 0);

    cur_req = "R7 random";
    for (int b = 0; b < 60; b++) begin
      write_cfg(lfsr[1:0], lfsr[6:2], lfsr[11:7] % 20, lfsr[12]);
      if (lfsr[15:13] == 3'd0) chan_en_i = ~chan_en_i;
      run(20 + lfsr[4:0], 2);
    end

    @(negedge clk_i);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule